// File: doc/BRIEF.md
# Bus Release Arbiter

This block sits in a processor's external bus interface and decides when the processor gives the shared bus to another master. It watches three requests from outside the processor. A hold request asks for the whole bus. An address-hold request asks only for the address lines, so that another master can run a snoop inquiry. An active-low backoff input asks for the bus at once. The block also watches three handshake signals from the processor's own bus-cycle engine.

From these inputs it drives three separate output enables: one for the address and byte-enable pins, one for the data and parity pins, and one for the bus control pins. It also drives the hold acknowledge, an abort strobe to the cycle engine, and a restart request after a cycle has been aborted. A grant signal controls when the engine may issue a new address strobe, and an error flag reports inquiries that arrive while the processor is in its low-power stop-grant state.

All outputs except `startGrant` are registered. Each follows the requests sampled on the previous rising edge of `clk`.

Top module: `busReleaseArb`

## Requirements
- R1: If `holdReq` is sampled high while a bus cycle is in progress (`cycActive`=1 and `cycDone`=0), `holdAck` stays low. It rises only on the edge after the edge that samples the cycle finishing (`cycDone`=1) or no cycle active.
- R2: On the edge that raises `holdAck`, `addrOe`, `dataOe` and `ctrlOe` all fall to 0 (1 = driven, 0 = high impedance).
- R3: An effective address-hold request (`addrHoldReq`=1, `stopGrant`=0) waits for an in-progress cycle in the same way as R1. It then drives only `addrOe` to 0, while `dataOe` and `ctrlOe` stay 1 and `holdAck` stays 0.
- R4: If `backoffN` is sampled 0, all three enables are 0 on the next edge, even when a cycle is in progress. `abortStb` pulses for one cycle on that edge when a cycle was in progress.
- R5: After a backoff aborts a cycle, `restartReq` pulses for exactly one cycle on the edge where the block next returns to owning the bus (all enables 1).
- R6: While `stopGrant`=1, `addrHoldReq` has no effect on the enables or on `holdAck`. `inquireErr` is 1 in the cycle after every edge that samples `addrHoldReq`=1 with `stopGrant`=1.
- R7: When several requests are active together, backoff wins over hold, and hold wins over address-hold. For example, `holdReq`=1 with `backoffN`=0 gives all enables 0 with `holdAck`=0.
- R8: `startGrant` follows `cycStartReq` only while the bus is owned and no request is active (`backoffN`=1, `holdReq`=0, no effective address-hold). Otherwise it is 0.
- R9: When `holdReq` is sampled 0 during hold acknowledge (with no other request active), `holdAck` drops and all three enables return to 1 on that same edge.
- R10: After reset, `holdAck`, `abortStb`, `restartReq` and `inquireErr` are 0, and all three enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReq | input | 1 | Request for the whole bus |
| addrHoldReq | input | 1 | Request for the address lines (snoop inquiry) |
| backoffN | input | 1 | Active-low immediate backoff |
| stopGrant | input | 1 | Processor is in the stop-grant low-power state |
| cycStartReq | input | 1 | Cycle engine wants to issue an address strobe |
| cycActive | input | 1 | A bus cycle is in progress |
| cycDone | input | 1 | Current bus cycle finishes in this clock |
| startGrant | output | 1 | Engine may start a new cycle now |
| holdAck | output | 1 | Hold acknowledge |
| addrOe | output | 1 | Drive enable, address and byte-enable pins |
| dataOe | output | 1 | Drive enable, data and parity pins |
| ctrlOe | output | 1 | Drive enable, bus control pins |
| abortStb | output | 1 | One-cycle abort of the in-progress cycle |
| restartReq | output | 1 | One-cycle request to reissue the aborted cycle |
| inquireErr | output | 1 | Inquiry arrived during stop-grant |

## Verification
The assertions assume that the cycle engine starts a cycle only in the clock after `startGrant`. They also assume that it drops `cycActive` once `abortStb` is seen, and that `cycDone` is raised only together with `cycActive`. The bench meets these assumptions with a small engine model. That model raises `cycStartReq` only while idle, runs a cycle of fixed or random length only after a grant, and clears its cycle on an expected abort. The requests change rarely and at random under a fixed seed, so that long hold, address-hold and backoff periods overlap with busy cycles and with stop-grant periods.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

  typedef enum logic [2:0] {
    ST_OWN        = 3'd0,
    ST_WAIT_HOLD  = 3'd1,
    ST_HOLD       = 3'd2,
    ST_WAIT_AHOLD = 3'd3,
    ST_AHOLD      = 3'd4,
    ST_BACKOFF    = 3'd5
  } relState_t;

  typedef struct packed {
    logic ackNext;
    logic addrOffNext;
    logic restOffNext;
    logic abortNext;
    logic restartNext;
    logic inqErrNext;
  } relStrobe_t;

  localparam int STROBE_W = $bits(relStrobe_t);

endpackage

// File: rtl/busrel_ctrl.sv
module busrel_ctrl
  import busrel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       addrHoldReq,
  input  logic       backoffN,
  input  logic       stopGrant,
  input  logic       cycStartReq,
  input  logic       cycActive,
  input  logic       cycDone,
  output relStrobe_t strobes,
  output logic       startGrant
);

  relState_t state, nextState;
  logic      busy, aholdEff, enterAbort, pendRestart;

  always_comb begin
    busy     = cycActive && !cycDone && (state != ST_BACKOFF);
    aholdEff = addrHoldReq && !stopGrant;
    if (!backoffN)     nextState = ST_BACKOFF;
    else if (holdReq)  nextState = busy ? ST_WAIT_HOLD : ST_HOLD;
    else if (aholdEff) nextState = busy ? ST_WAIT_AHOLD : ST_AHOLD;
    else               nextState = ST_OWN;
    enterAbort = (nextState == ST_BACKOFF) && busy;
  end

  always_comb begin
    strobes.ackNext     = (nextState == ST_HOLD);
    strobes.addrOffNext = (nextState == ST_HOLD) || (nextState == ST_AHOLD) ||
                          (nextState == ST_BACKOFF);
    strobes.restOffNext = (nextState == ST_HOLD) || (nextState == ST_BACKOFF);
    strobes.abortNext   = enterAbort;
    strobes.restartNext = (nextState == ST_OWN) && pendRestart;
    strobes.inqErrNext  = addrHoldReq && stopGrant;
  end

  assign startGrant = cycStartReq && (state == ST_OWN) && backoffN &&
                      !holdReq && !aholdEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_OWN;
      pendRestart <= 1'b0;
    end else begin
      state <= nextState;
      if (enterAbort)                pendRestart <= 1'b1;
      else if (nextState == ST_OWN)  pendRestart <= 1'b0;
    end
  end

  // R1: a busy cycle defers the hold acknowledge
  p_hold_waits_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWN && backoffN && holdReq && cycActive && !cycDone)
      |=> (state == ST_WAIT_HOLD));

  // R3: address-hold also lets the cycle finish
  p_ahold_waits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWN && backoffN && !holdReq && addrHoldReq && !stopGrant &&
     cycActive && !cycDone) |=> (state == ST_WAIT_AHOLD));

  // R8: the engine starts only while the bus is owned
  p_grant_owned_r8: assert property (@(posedge clk) disable iff (!rstN)
    startGrant |-> (state == ST_OWN));

  // R5: a restart is a single pulse
  p_restart_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restartNext |=> !strobes.restartNext);

endmodule

// File: rtl/busrel_dp.sv
module busrel_dp
  import busrel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  relStrobe_t strobes,
  output logic       holdAck,
  output logic       addrOe,
  output logic       dataOe,
  output logic       ctrlOe,
  output logic       abortStb,
  output logic       restartReq,
  output logic       inquireErr
);

  logic addrOffR, restOffR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAck    <= 1'b0;
      addrOffR   <= 1'b0;
      restOffR   <= 1'b0;
      abortStb   <= 1'b0;
      restartReq <= 1'b0;
      inquireErr <= 1'b0;
    end else begin
      holdAck    <= strobes.ackNext;
      addrOffR   <= strobes.addrOffNext;
      restOffR   <= strobes.restOffNext;
      abortStb   <= strobes.abortNext;
      restartReq <= strobes.restartNext;
      inquireErr <= strobes.inqErrNext;
    end
  end

  assign addrOe = !addrOffR;
  assign dataOe = !restOffR;
  assign ctrlOe = !restOffR;

  // R2: acknowledge only with every pin group floated
  p_ack_float_r2: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!addrOe && !dataOe && !ctrlOe));

  // R3: address-only float keeps control driven and no acknowledge
  p_addr_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!addrOe && dataOe) |-> (ctrlOe && !holdAck));

endmodule

// File: rtl/busReleaseArb.sv
module busReleaseArb
  import busrel_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic holdReq,
  input  logic addrHoldReq,
  input  logic backoffN,
  input  logic stopGrant,
  input  logic cycStartReq,
  input  logic cycActive,
  input  logic cycDone,
  output logic startGrant,
  output logic holdAck,
  output logic addrOe,
  output logic dataOe,
  output logic ctrlOe,
  output logic abortStb,
  output logic restartReq,
  output logic inquireErr
);

  relStrobe_t strobes;

  busrel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .holdReq    (holdReq),
    .addrHoldReq(addrHoldReq),
    .backoffN   (backoffN),
    .stopGrant  (stopGrant),
    .cycStartReq(cycStartReq),
    .cycActive  (cycActive),
    .cycDone    (cycDone),
    .strobes    (strobes),
    .startGrant (startGrant)
  );

  busrel_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .holdAck   (holdAck),
    .addrOe    (addrOe),
    .dataOe    (dataOe),
    .ctrlOe    (ctrlOe),
    .abortStb  (abortStb),
    .restartReq(restartReq),
    .inquireErr(inquireErr)
  );

  // R4: backoff floats everything on the next edge
  p_backoff_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    !backoffN |=> (!addrOe && !dataOe && !ctrlOe && !holdAck));

  // R7: backoff outranks hold
  p_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && !backoffN) |=> !holdAck);

  // R6: inquiry during stop-grant is flagged
  p_stopgrant_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopGrant && addrHoldReq) |=> inquireErr);

  // R9: releasing hold restores the bus on one edge
  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq && backoffN && !addrHoldReq)
      |=> (!holdAck && addrOe && dataOe && ctrlOe));

endmodule

// File: tb/tb_busReleaseArb.sv
`timescale 1ns/1ps
module tb_busReleaseArb;

  localparam int M_OWN = 0, M_WH = 1, M_HOLD = 2, M_WA = 3, M_AH = 4, M_BOFF = 5;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 0, addrHoldReq = 0, backoffN = 1, stopGrant = 0;
  logic cycStartReq = 0, cycActive = 0, cycDone = 0;
  logic startGrant, holdAck, addrOe, dataOe, ctrlOe, abortStb, restartReq, inquireErr;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  int  mSt = M_OWN;
  bit  mPend = 0;
  logic eAck = 0, eAddr = 1, eData = 1, eAbort = 0, eRestart = 0, eInq = 0, eGrant = 0;
  bit  lastGrant = 0;
  int  engRemain = 0;
  int  nextLen = 2;

  always #2.5 clk = ~clk;

  busReleaseArb dut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .addrHoldReq(addrHoldReq),
    .backoffN(backoffN), .stopGrant(stopGrant), .cycStartReq(cycStartReq),
    .cycActive(cycActive), .cycDone(cycDone), .startGrant(startGrant),
    .holdAck(holdAck), .addrOe(addrOe), .dataOe(dataOe), .ctrlOe(ctrlOe),
    .abortStb(abortStb), .restartReq(restartReq), .inquireErr(inquireErr)
  );

  task automatic chk(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic int nextMode(input int st, input logic h, input logic a,
                                  input logic b, input logic s, input bit busy);
    if (!b) return M_BOFF;
    if (h) return busy ? M_WH : M_HOLD;
    if (a && !s) return busy ? M_WA : M_AH;
    return M_OWN;
  endfunction

  task automatic step(input logic h, input logic a, input logic b, input logic s,
                      input logic r, input string tag);
    bit busy, enterAb;
    int nxt;
    @(negedge clk);
    chk(tag, "R2 holdAck",     holdAck,    eAck);
    chk(tag, "R3 addrOe",      addrOe,     eAddr);
    chk(tag, "R2 dataOe",      dataOe,     eData);
    chk(tag, "R2 ctrlOe",      ctrlOe,     eData);
    chk(tag, "R4 abortStb",    abortStb,   eAbort);
    chk(tag, "R5 restartReq",  restartReq, eRestart);
    chk(tag, "R6 inquireErr",  inquireErr, eInq);
    // engine model
    if (eAbort) engRemain = 0;
    else if (engRemain > 0) engRemain--;
    if (lastGrant) engRemain = nextLen;
    holdReq = h; addrHoldReq = a; backoffN = b; stopGrant = s;
    cycStartReq = r && (engRemain == 0);
    cycActive = (engRemain > 0);
    cycDone = (engRemain == 1);
    #1;
    eGrant = cycStartReq && (mSt == M_OWN) && b && !h && !(a && !s);
    chk(tag, "R8 startGrant", startGrant, eGrant);
    lastGrant = eGrant;
    busy = cycActive && !cycDone && (mSt != M_BOFF);
    nxt = nextMode(mSt, h, a, b, s, busy);
    enterAb = (nxt == M_BOFF) && busy;
    eAck = (nxt == M_HOLD);
    eAddr = !((nxt == M_HOLD) || (nxt == M_AH) || (nxt == M_BOFF));
    eData = !((nxt == M_HOLD) || (nxt == M_BOFF));
    eAbort = enterAb;
    eRestart = (nxt == M_OWN) && mPend;
    eInq = a && s;
    if (enterAb) mPend = 1;
    else if (nxt == M_OWN) mPend = 0;
    mSt = nxt;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic h, a, b, s;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "holdAck", holdAck, 1'b0);
    chk("R10", "addrOe", addrOe, 1'b1);
    chk("R10", "dataOe", dataOe, 1'b1);
    chk("R10", "ctrlOe", ctrlOe, 1'b1);
    chk("R10", "pulses", abortStb | restartReq | inquireErr, 1'b0);
    rstN = 1'b1;

    // R1: hold arrives during a three-clock cycle
    nextLen = 3;
    step(0, 0, 1, 0, 1, "R1");
    step(1, 0, 1, 0, 0, "R1");
    step(1, 0, 1, 0, 0, "R1");
    step(1, 0, 1, 0, 0, "R1");
    step(1, 0, 1, 0, 0, "R1");
    // R9: release hold
    step(0, 0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, 0, "R9");
    chk("R9", "explicit holdAck low", holdAck, 1'b0);
    // R3: address-hold during a busy cycle
    step(0, 0, 1, 0, 1, "R3");
    step(0, 1, 1, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3");
    // R4/R5: backoff aborts a cycle then restart
    nextLen = 4;
    step(0, 0, 1, 0, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    // R7: all requests together, then backoff released under hold
    step(1, 1, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 0, "R7");
    step(0, 1, 1, 0, 0, "R7");
    step(0, 0, 1, 0, 0, "R7");
    // R6: inquiry during stop-grant
    step(0, 1, 1, 1, 1, "R6");
    step(0, 1, 1, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");

    // random phase
    h = 0; a = 0; b = 1; s = 0;
    for (int i = 0; i < RAND_CYCLES; i++) begin
      if ($urandom_range(9) == 0) h = !h;
      if ($urandom_range(9) == 0) a = !a;
      if ($urandom_range(13) == 0) b = !b;
      if ($urandom_range(29) == 0) s = !s;
      nextLen = 1 + $urandom_range(4);
      step(h, a, b, s, logic'($urandom_range(1)), "RND");
    end
    step(0, 0, 1, 0, 0, "RND");
    step(0, 0, 1, 0, 0, "RND");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule